// File: doc/BRIEF.md
# Ordering Table Clear Engine

This engine prepares a depth-ordering table in memory before a frame is drawn. When it is given a start address and an entry count, it writes that many 32-bit words, moving down through memory one word at a time. Each word links to the word just below it, so the table reads as an empty chain. The lowest word holds an end-of-chain marker instead of a link.

A command word selects the fill. Only one command value starts a fill. Any other value, and an entry count of zero, completes at once with no memory traffic. The engine holds `busy` high while a fill runs. It issues one write per cycle, and each write is accepted when the memory port signals ready. After the final accepted write it drops `busy` and raises `irq` for a single cycle.

Top module: `otc_clear_engine`

## Requirements
- R1: After reset, `busy`, `irq` and `mem_wr_en` are all low.
- R2: A `start` pulse while idle with `ctrl_word` other than 0x11000002 causes no write and leaves `busy` low. `irq` is high for one cycle, in the cycle after `start` is sampled.
- R3: A `start` pulse with `ctrl_word` equal to 0x11000002 and `entry_count` of zero behaves like R2: there is no write, and `irq` pulses one cycle later.
- R4: A valid start (command 0x11000002 and a nonzero count N) raises `busy` in the cycle after `start` is sampled. Exactly N writes follow. Write k (counting from 0) goes to word address `base - 4k` modulo 2^24, where `base` is `base_addr` with its two low bits forced to zero.
- R5: For every write except the last, the data equals that write's own address minus 4, modulo 2^24, with bits 31:24 zero.
- R6: The last write carries the end marker 0x00FFFFFF.
- R7: While `mem_ready` is low during a fill, `mem_wr_en` stays high and the address and data hold steady. `busy` lasts exactly N cycles plus the number of stalled cycles.
- R8: In the cycle after the last write is accepted, `busy` is low and `irq` is high. `irq` is low again in the following cycle.
- R9: A `start` pulse while `busy` is high is ignored. The write sequence in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Single-cycle request to run a command |
| ctrl_word | input | 32 | Command word; 0x11000002 selects the fill |
| base_addr | input | 24 | Address of the first (highest) entry |
| entry_count | input | CNT_W | Number of 32-bit entries to write |
| mem_ready | input | 1 | Memory port accepts the current write |
| mem_wr_en | output | 1 | Write request |
| mem_wr_addr | output | 24 | Write word address |
| mem_wr_data | output | 32 | Write data |
| busy | output | 1 | Fill in progress |
| irq | output | 1 | One-cycle completion pulse |

## Verification
A corrupted address register shows on the very next write as a wrong `mem_wr_addr`. From then on every link is also wrong, because the data is derived from the address. A miscounted remaining-entries register shows at the end of the fill. The marker appears on the wrong beat, and `busy` falls early or late against the expected N plus stalls. The error shows up no later than the cycle the fill should have ended. The bench sweeps counts from 0 to 6 over several bases, including wrap through zero and an unaligned base, under three stall patterns. It checks every beat, so these faults surface within a single run.

// File: rtl/otc_pkg.sv
package otc_pkg;
    localparam int LINK_W = 24;
    localparam int DATA_W = 32;
    localparam logic [DATA_W-1:0] FILL_CMD = 32'h1100_0002;
    localparam logic [LINK_W-1:0] END_MARK = {LINK_W{1'b1}};

    typedef struct packed {
        logic [LINK_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_beat_t;

    function automatic logic [LINK_W-1:0] prev_link(input logic [LINK_W-1:0] a);
        return a - LINK_W'(4);
    endfunction

    function automatic logic [LINK_W-1:0] word_align(input logic [LINK_W-1:0] a);
        return {a[LINK_W-1:2], 2'b00};
    endfunction

    function automatic logic [DATA_W-1:0] widen(input logic [LINK_W-1:0] a);
        return {{(DATA_W-LINK_W){1'b0}}, a};
    endfunction
endpackage

// File: rtl/otc_cmd_decode.sv
module otc_cmd_decode
    import otc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              start,
    input  logic              idle,
    input  logic [DATA_W-1:0] ctrl_word,
    input  logic [CNT_W-1:0]  entry_count,
    output logic              launch,
    output logic              abort
);
    logic accept;
    logic has_work;

    always_comb begin
        accept   = start && idle;
        has_work = (ctrl_word == FILL_CMD) && (entry_count != '0);
        launch   = accept && has_work;
        abort    = accept && !has_work;
    end
endmodule

// File: rtl/otc_walker.sv
module otc_walker
    import otc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic [LINK_W-1:0] base_addr,
    input  logic [CNT_W-1:0]  entry_count,
    input  logic              mem_ready,
    output logic              busy,
    output logic              last_accept,
    output wr_beat_t          beat
);
    logic [LINK_W-1:0] cur_addr;
    logic [CNT_W-1:0]  remain;
    logic              on_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            cur_addr <= '0;
            remain   <= '0;
        end else if (launch) begin
            busy     <= 1'b1;
            cur_addr <= word_align(base_addr);
            remain   <= entry_count;
        end else if (busy && mem_ready) begin
            cur_addr <= prev_link(cur_addr);
            remain   <= remain - CNT_W'(1);
            if (on_last) busy <= 1'b0;
        end
    end

    always_comb begin
        on_last     = (remain == CNT_W'(1));
        last_accept = busy && mem_ready && on_last;
        beat.addr   = cur_addr;
        beat.data   = on_last ? widen(END_MARK) : widen(prev_link(cur_addr));
    end
endmodule

// File: rtl/otc_clear_engine.sv
module otc_clear_engine
    import otc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [31:0]       ctrl_word,
    input  logic [23:0]       base_addr,
    input  logic [CNT_W-1:0]  entry_count,
    input  logic              mem_ready,
    output logic              mem_wr_en,
    output logic [23:0]       mem_wr_addr,
    output logic [31:0]       mem_wr_data,
    output logic              busy,
    output logic              irq
);
    logic     launch;
    logic     abort;
    logic     last_accept;
    logic     walk_busy;
    wr_beat_t beat;

    otc_cmd_decode #(.CNT_W(CNT_W)) u_dec (
        .start       (start),
        .idle        (!walk_busy),
        .ctrl_word   (ctrl_word),
        .entry_count (entry_count),
        .launch      (launch),
        .abort       (abort)
    );

    otc_walker #(.CNT_W(CNT_W)) u_walk (
        .clk         (clk),
        .rst         (rst),
        .launch      (launch),
        .base_addr   (base_addr),
        .entry_count (entry_count),
        .mem_ready   (mem_ready),
        .busy        (walk_busy),
        .last_accept (last_accept),
        .beat        (beat)
    );

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= last_accept || abort;
    end

    always_comb begin
        busy        = walk_busy;
        mem_wr_en   = walk_busy;
        mem_wr_addr = beat.addr;
        mem_wr_data = beat.data;
    end
endmodule

// File: rtl/otc_clear_chk.sv
module otc_clear_chk (
    input logic        clk,
    input logic        rst,
    input logic        mem_ready,
    input logic        mem_wr_en,
    input logic [23:0] mem_wr_addr,
    input logic [31:0] mem_wr_data,
    input logic        busy,
    input logic        irq
);
    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en && !mem_ready) |=> (mem_wr_en && $stable(mem_wr_addr) && $stable(mem_wr_data)));

    // R8
    irq_single_chk: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R8
    busy_end_irq_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> irq);

    // R4
    descend_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en && mem_ready) |=> (!mem_wr_en || (mem_wr_addr == $past(mem_wr_addr) - 24'd4)));

    // R6
    marker_last_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en && mem_ready && mem_wr_data[1:0] == 2'b11) |=> !busy);

    // R5
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> (mem_wr_data[31:24] == 8'h00));
endmodule

bind otc_clear_engine otc_clear_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .mem_ready   (mem_ready),
    .mem_wr_en   (mem_wr_en),
    .mem_wr_addr (mem_wr_addr),
    .mem_wr_data (mem_wr_data),
    .busy        (busy),
    .irq         (irq)
);

// File: tb/tb_otc_clear_engine.sv
`timescale 1ns/1ps
module tb_otc_clear_engine;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [31:0] ctrl_word;
    logic [23:0] base_addr;
    logic [31:0] entry_count;
    logic        mem_ready;
    logic        mem_wr_en;
    logic [23:0] mem_wr_addr;
    logic [31:0] mem_wr_data;
    logic        busy;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always #2.5 clk = ~clk;

    otc_clear_engine #(.CNT_W(32)) dut (
        .clk(clk), .rst(rst), .start(start), .ctrl_word(ctrl_word),
        .base_addr(base_addr), .entry_count(entry_count), .mem_ready(mem_ready),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .busy(busy), .irq(irq)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual cycle %0d expected below 150000", cyc);
            summary();
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic pick_ready(input int mode, input int step);
        case (mode)
            0:       return 1'b1;
            1:       return (step % 2) == 1;
            default: return (step % 3) != 0;
        endcase
    endfunction

    task automatic run_abort(input logic [31:0] cmd, input logic [31:0] cnt, string req);
        @(negedge clk);
        ctrl_word = cmd; base_addr = 24'h000400; entry_count = cnt; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({req, " busy low"}, {31'b0, busy}, 32'd0);
        check({req, " irq pulse"}, {31'b0, irq}, 32'd1);
        check({req, " no write"}, {31'b0, mem_wr_en}, 32'd0);
        @(negedge clk);
        check({req, " irq ends"}, {31'b0, irq}, 32'd0);
        check({req, " still no write"}, {31'b0, mem_wr_en}, 32'd0);
    endtask

    task automatic run_fill(input logic [23:0] base, input int n, input int mode, input bit poke);
        logic [23:0] a0;
        logic [23:0] ea;
        logic [31:0] ed;
        int k = 0;
        int busy_cyc = 0;
        int stalls = 0;
        int step = 0;
        logic rdy;
        a0 = {base[23:2], 2'b00};
        @(negedge clk);
        ctrl_word = 32'h1100_0002; base_addr = base; entry_count = n; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R4 busy rises", {31'b0, busy}, 32'd1);
        while (busy && busy_cyc < 200) begin
            ea = a0 - 24'(4 * k);
            ed = (k == n - 1) ? 32'h00FF_FFFF : {8'h00, ea - 24'd4};
            check("R7 write enable", {31'b0, mem_wr_en}, 32'd1);
            check("R4 address", {8'h00, mem_wr_addr}, {8'h00, ea});
            if (k == n - 1) check("R6 end marker", mem_wr_data, ed);
            else            check("R5 link data", mem_wr_data, ed);
            rdy = pick_ready(mode, step);
            mem_ready = rdy;
            if (poke && step == 1) begin
                start = 1'b1; base_addr = 24'h00F000; entry_count = 2;
            end else begin
                start = 1'b0;
            end
            if (rdy) k++;
            else     stalls++;
            busy_cyc++;
            step++;
            @(negedge clk);
        end
        start = 1'b0;
        mem_ready = 1'b1;
        check("R4 write count", k, n);
        check("R7 busy length", busy_cyc, n + stalls);
        check("R8 irq at end", {31'b0, irq}, 32'd1);
        check("R8 busy low at end", {31'b0, busy}, 32'd0);
        @(negedge clk);
        check("R8 irq single", {31'b0, irq}, 32'd0);
        check("R9 no restart", {31'b0, busy}, 32'd0);
    endtask

    initial begin
        logic [23:0] bases [5];
        bases[0] = 24'h000100; bases[1] = 24'h000008; bases[2] = 24'h000000;
        bases[3] = 24'hFFFFFC; bases[4] = 24'h000106;
        rst = 1'b1; start = 1'b0; ctrl_word = '0; base_addr = '0;
        entry_count = '0; mem_ready = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 busy reset", {31'b0, busy}, 32'd0);
        check("R1 irq reset", {31'b0, irq}, 32'd0);
        check("R1 wr_en reset", {31'b0, mem_wr_en}, 32'd0);
        rst = 1'b0;

        run_abort(32'h1100_0001, 5, "R2");
        run_abort(32'h0100_0002, 5, "R2");
        run_abort(32'h0000_0000, 3, "R2");
        run_abort(32'h1100_0003, 1, "R2");
        run_abort(32'h1100_0002, 0, "R3");

        for (int b = 0; b < 5; b++)
            for (int n = 1; n <= 6; n++)
                for (int m = 0; m < 3; m++)
                    run_fill(bases[b], n, m, (m == 1) && (n >= 3));

        summary();
    end
endmodule